// File: doc/BRIEF.md
# Abstract Register-Access Instruction Generator

When a debugger asks a halted hart to move a general-purpose register in or out of the debug data area, the hart does not expose its register file directly. It runs a short stub of machine code that the debug logic writes in front of the debugger's own program buffer. This block produces that stub. It accepts one access-register command word and returns two 32-bit RISC-V instruction words. The first is the transfer word. The second is the tail word, which either stops the hart or lets it continue into the program buffer.

The transfer word is a load or a store between the selected register and address 0x400, formed as x0 plus a 12-bit immediate. It comes in word, doubleword or quadword form according to the access size. When the command asks for no transfer, the transfer word is a nop. When a command names something that is not a general register, or asks for a size the block does not support, the block raises an error flag. In that case neither word performs any work. The result is registered and appears one cycle after a start strobe. It then holds until the next strobe.

Top module: `areg_insn_gen`

## Requirements
- R1: While reset is high and after it ends, `valid` and `err` are 0, `xfer_word` is the nop 0x00000013 and `tail_word` is the ebreak 0x00100073.
- R2: `valid` is 1 in exactly the cycle after a cycle with `start` high. The three result outputs change only on an edge where `start` is high, and they hold their values otherwise.
- R3: The command layout is: `cmd_bits[15:0]` register number, bit 16 write, bit 17 transfer, bit 18 postexec, bits [21:19] size (2 = 32-bit, 3 = 64-bit, 4 = 128-bit). A read is transfer=1 and write=0. It yields a load with rd equal to the register number's low 5 bits, rs1 = x0 and immediate 0x400. The opcode is 0000011 with funct3 010 for 32-bit and 011 for 64-bit. For 128-bit the opcode is 0001111 with funct3 010.
- R4: A write is transfer=1 and write=1. It yields a store with opcode 0100011, rs2 equal to the register number's low 5 bits and rs1 = x0. The immediate 0x400 is split so that bits [31:25] = 0100000 and bits [11:7] = 00000. funct3 is 010, 011 or 100 for 32, 64 or 128 bits.
- R5: With transfer=0 the transfer word is the nop 0x00000013 and `err` stays 0, whatever the register number, size and write bit hold.
- R6: Without an error, the tail word is the nop 0x00000013 when postexec=1, so execution falls through to the program buffer. It is the ebreak 0x00100073 when postexec=0.
- R7: With transfer=1 and a register number outside 0x1000..0x101F, `err` is 1 and both words are the ebreak 0x00100073.
- R8: With transfer=1 and a size outside 2..MAX_SIZE (default 4), `err` is 1 and both words are the ebreak 0x00100073.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe: capture and translate `cmd_bits` |
| cmd_bits | input | 22 | Access-register command word |
| valid | output | 1 | Result was produced by the previous strobe |
| err | output | 1 | Unsupported register or size |
| xfer_word | output | 32 | Transfer instruction word |
| tail_word | output | 32 | Tail instruction word (ebreak or nop) |

## Verification
The hardest cases to reach are at the register-range boundaries. Numbers such as 0x0FFF and 0x1020 sit just outside the accepted range, and they must raise an error only when transfer is set. The same invalid fields with transfer clear must pass silently. Uniform random register numbers almost never land at these edges. The stimulus therefore biases most random commands into the valid range and draws the rest from the whole 16-bit space. Directed commands then place register numbers exactly at both edges, combine them with illegal sizes, and repeat each with transfer cleared.

// File: rtl/areg_pkg.sv
`timescale 1ns/1ps
package areg_pkg;

    localparam int CMD_W        = 22;
    localparam int XFER_BIT     = 17;
    localparam logic [31:0] INSN_NOP    = 32'h0000_0013;
    localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;
    localparam logic [11:0] DATA_OFS    = 12'h400;

    localparam logic [6:0] OPC_LOAD     = 7'b0000011;
    localparam logic [6:0] OPC_STORE    = 7'b0100011;
    localparam logic [6:0] OPC_MISC_MEM = 7'b0001111;

    typedef enum logic [2:0] {
        SZ_32  = 3'd2,
        SZ_64  = 3'd3,
        SZ_128 = 3'd4
    } acc_size_e;

    typedef struct packed {
        logic [2:0]  size;
        logic        postexec;
        logic        transfer;
        logic        write;
        logic [15:0] regno;
    } cmd_t;

    function automatic logic [31:0] enc_itype(input logic [11:0] imm,
                                              input logic [4:0]  rs1,
                                              input logic [2:0]  f3,
                                              input logic [4:0]  rd,
                                              input logic [6:0]  opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] enc_stype(input logic [11:0] imm,
                                              input logic [4:0]  rs2,
                                              input logic [4:0]  rs1,
                                              input logic [2:0]  f3,
                                              input logic [6:0]  opc);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
    endfunction

endpackage

// File: rtl/areg_cmd_decode.sv
`timescale 1ns/1ps
module areg_cmd_decode
    import areg_pkg::*;
#(
    parameter int          MAX_SIZE = 4,
    parameter logic [15:0] GPR_BASE = 16'h1000,
    parameter int          NUM_GPR  = 32
) (
    input  cmd_t       cmd,
    output logic [4:0] gpr_idx,
    output logic       bad_cmd
);
    localparam logic [15:0] GPR_LAST = GPR_BASE + 16'(NUM_GPR - 1);

    logic reg_bad;
    logic size_bad;

    always_comb begin
        gpr_idx  = cmd.regno[4:0];
        reg_bad  = (cmd.regno < GPR_BASE) || (cmd.regno > GPR_LAST);
        size_bad = (int'(cmd.size) < int'(SZ_32)) || (int'(cmd.size) > MAX_SIZE);
        bad_cmd  = cmd.transfer && (reg_bad || size_bad);
    end
endmodule

// File: rtl/areg_xfer_enc.sv
`timescale 1ns/1ps
module areg_xfer_enc
    import areg_pkg::*;
#(
    parameter int MAX_SIZE = 4
) (
    input  logic       transfer,
    input  logic       write,
    input  logic [2:0] size,
    input  logic [4:0] gpr_idx,
    output logic [31:0] word
);
    localparam bit HAS_QUAD = (MAX_SIZE >= 4);

    logic [31:0] quad_ld;
    logic [31:0] quad_st;
    logic [31:0] word_ld;
    logic [31:0] word_st;
    logic [31:0] dbl_ld;
    logic [31:0] dbl_st;

    assign word_ld = enc_itype(DATA_OFS, 5'd0, 3'b010, gpr_idx, OPC_LOAD);
    assign dbl_ld  = enc_itype(DATA_OFS, 5'd0, 3'b011, gpr_idx, OPC_LOAD);
    assign word_st = enc_stype(DATA_OFS, gpr_idx, 5'd0, 3'b010, OPC_STORE);
    assign dbl_st  = enc_stype(DATA_OFS, gpr_idx, 5'd0, 3'b011, OPC_STORE);

    generate
        if (HAS_QUAD) begin : g_quad
            assign quad_ld = enc_itype(DATA_OFS, 5'd0, 3'b010, gpr_idx, OPC_MISC_MEM);
            assign quad_st = enc_stype(DATA_OFS, gpr_idx, 5'd0, 3'b100, OPC_STORE);
        end else begin : g_no_quad
            assign quad_ld = INSN_NOP;
            assign quad_st = INSN_NOP;
        end
    endgenerate

    always_comb begin
        word = INSN_NOP;
        if (transfer) begin
            unique case (size)
                SZ_32:   word = write ? word_st : word_ld;
                SZ_64:   word = write ? dbl_st  : dbl_ld;
                SZ_128:  word = write ? quad_st : quad_ld;
                default: word = INSN_NOP;
            endcase
        end
    end
endmodule

// File: rtl/areg_insn_gen.sv
`timescale 1ns/1ps
module areg_insn_gen
    import areg_pkg::*;
#(
    parameter int          MAX_SIZE = 4,
    parameter logic [15:0] GPR_BASE = 16'h1000,
    parameter int          NUM_GPR  = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [CMD_W-1:0]    cmd_bits,
    output logic                valid,
    output logic                err,
    output logic [31:0]         xfer_word,
    output logic [31:0]         tail_word
);
    cmd_t        cmd;
    logic [4:0]  gpr_idx;
    logic        bad_cmd;
    logic [31:0] xfer_next;
    logic [31:0] tail_next;

    assign cmd = cmd_t'(cmd_bits);

    areg_cmd_decode #(
        .MAX_SIZE (MAX_SIZE),
        .GPR_BASE (GPR_BASE),
        .NUM_GPR  (NUM_GPR)
    ) u_decode (
        .cmd     (cmd),
        .gpr_idx (gpr_idx),
        .bad_cmd (bad_cmd)
    );

    areg_xfer_enc #(
        .MAX_SIZE (MAX_SIZE)
    ) u_xfer (
        .transfer (cmd.transfer),
        .write    (cmd.write),
        .size     (cmd.size),
        .gpr_idx  (gpr_idx),
        .word     (xfer_next)
    );

    assign tail_next = cmd.postexec ? INSN_NOP : INSN_EBREAK;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid     <= 1'b0;
            err       <= 1'b0;
            xfer_word <= INSN_NOP;
            tail_word <= INSN_EBREAK;
        end else begin
            valid <= start;
            if (start) begin
                err       <= bad_cmd;
                xfer_word <= bad_cmd ? INSN_EBREAK : xfer_next;
                tail_word <= bad_cmd ? INSN_EBREAK : tail_next;
            end
        end
    end
endmodule

// File: rtl/areg_insn_gen_chk.sv
`timescale 1ns/1ps
module areg_insn_gen_chk
    import areg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CMD_W-1:0] cmd_bits,
    input logic             valid,
    input logic             err,
    input logic [31:0]      xfer_word,
    input logic [31:0]      tail_word
);
    logic unused_cmd_rest;
    assign unused_cmd_rest = ^{cmd_bits[CMD_W-1:XFER_BIT+1], cmd_bits[XFER_BIT-1:0]};

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> valid); // R2

    AST_VALID_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(start)); // R2

    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> ($stable(xfer_word) && $stable(tail_word) && $stable(err))); // R2

    AST_ERR_BOTH_EBREAK: assert property (@(posedge clk) disable iff (rst)
        err |-> (xfer_word == INSN_EBREAK && tail_word == INSN_EBREAK)); // R7

    AST_NOXFER_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        ($past(start) && !$past(cmd_bits[XFER_BIT])) |-> (!err && xfer_word == INSN_NOP)); // R5

    AST_TAIL_FORM: assert property (@(posedge clk) disable iff (rst)
        (valid && !err) |-> (tail_word == INSN_NOP || tail_word == INSN_EBREAK)); // R6

    AST_XFER_BASE_X0: assert property (@(posedge clk) disable iff (rst)
        (valid && !err && xfer_word != INSN_NOP) |-> (xfer_word[19:15] == 5'd0)); // R3
endmodule

bind areg_insn_gen areg_insn_gen_chk u_chk (.*);

// File: tb/areg_insn_gen_tb.sv
`timescale 1ns/1ps
module areg_insn_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [21:0] cmd_bits = '0;
    logic        valid;
    logic        err;
    logic [31:0] xfer_word;
    logic [31:0] tail_word;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    areg_insn_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd_bits  (cmd_bits),
        .valid     (valid),
        .err       (err),
        .xfer_word (xfer_word),
        .tail_word (tail_word)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [21:0] mk(input logic [2:0] sz, input logic post,
                                       input logic xfer, input logic wr,
                                       input logic [15:0] reg_n);
        return {sz, post, xfer, wr, reg_n};
    endfunction

    // Expected result, built from the requirement text
    function automatic void model(input logic [21:0] c, output logic [31:0] x,
                                  output logic [31:0] t, output logic e);
        logic [15:0] rn  = c[15:0];
        logic        wr  = c[16];
        logic        tr  = c[17];
        logic        pe  = c[18];
        logic [2:0]  sz  = c[21:19];
        logic        rbad = (rn < 16'h1000) || (rn > 16'h101F);
        logic        sbad = (sz < 3'd2) || (sz > 3'd4);
        logic [2:0]  f3;
        logic [6:0]  op;
        e = tr && (rbad || sbad);
        t = pe ? 32'h0000_0013 : 32'h0010_0073;
        if (!tr) begin
            x = 32'h0000_0013;
        end else if (wr) begin
            f3 = (sz == 3'd2) ? 3'b010 : (sz == 3'd3) ? 3'b011 : 3'b100;
            x  = {7'b0100000, rn[4:0], 5'd0, f3, 5'd0, 7'b0100011};
        end else begin
            f3 = (sz == 3'd3) ? 3'b011 : 3'b010;
            op = (sz == 3'd4) ? 7'b0001111 : 7'b0000011;
            x  = {12'h400, 5'd0, f3, rn[4:0], op};
        end
        if (e) begin
            x = 32'h0010_0073;
            t = 32'h0010_0073;
        end
    endfunction

    task automatic apply(input logic [21:0] c);
        logic [31:0] ex, et;
        logic        ee;
        string       rx, re;
        model(c, ex, et, ee);
        rx = !c[17] ? "R5" : (c[16] ? "R4" : "R3");
        re = !c[17] ? "R5" : ((c[15:0] < 16'h1000 || c[15:0] > 16'h101F) ? "R7" : "R8");
        @(negedge clk);
        cmd_bits = c;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        chk("R2", "valid after start", {31'd0, valid}, 32'd1);
        chk(re, "err", {31'd0, err}, {31'd0, ee});
        chk(ee ? re : rx, "xfer_word", xfer_word, ex);
        chk(ee ? re : "R6", "tail_word", tail_word, et);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] hx, ht;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state, during and after reset
        chk("R1", "valid in reset", {31'd0, valid}, 32'd0);
        chk("R1", "xfer in reset", xfer_word, 32'h0000_0013);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", {31'd0, valid}, 32'd0);
        chk("R1", "err after reset", {31'd0, err}, 32'd0);
        chk("R1", "xfer after reset", xfer_word, 32'h0000_0013);
        chk("R1", "tail after reset", tail_word, 32'h0010_0073);

        // R3 / R4 known encodings
        apply(mk(3'd2, 1'b0, 1'b1, 1'b0, 16'h1005));
        chk("R3", "lw x5 literal", xfer_word, 32'h4000_2283);
        apply(mk(3'd3, 1'b0, 1'b1, 1'b0, 16'h100A));
        chk("R3", "ld x10 literal", xfer_word, 32'h4000_3503);
        apply(mk(3'd2, 1'b1, 1'b1, 1'b1, 16'h1005));
        chk("R4", "sw x5 literal", xfer_word, 32'h4050_2023);
        chk("R6", "postexec nop", tail_word, 32'h0000_0013);
        apply(mk(3'd4, 1'b0, 1'b1, 1'b1, 16'h101F));
        apply(mk(3'd4, 1'b1, 1'b1, 1'b0, 16'h1000));

        // R7 / R8 boundaries, and R5 with the same fields
        apply(mk(3'd2, 1'b0, 1'b1, 1'b0, 16'h0FFF));
        apply(mk(3'd2, 1'b0, 1'b1, 1'b1, 16'h1020));
        apply(mk(3'd5, 1'b0, 1'b1, 1'b0, 16'h1001));
        apply(mk(3'd1, 1'b1, 1'b1, 1'b1, 16'h1001));
        apply(mk(3'd7, 1'b1, 1'b1, 1'b0, 16'hFFFF));
        apply(mk(3'd7, 1'b1, 1'b0, 1'b1, 16'hFFFF));
        apply(mk(3'd0, 1'b0, 1'b0, 1'b0, 16'h0FFF));
        apply(mk(3'd2, 1'b1, 1'b0, 1'b1, 16'h1020));

        // R2: outputs hold without a strobe, valid drops
        hx = xfer_word;
        ht = tail_word;
        cmd_bits = mk(3'd3, 1'b0, 1'b1, 1'b1, 16'h1003);
        repeat (3) @(negedge clk);
        chk("R2", "valid low without start", {31'd0, valid}, 32'd0);
        chk("R2", "xfer holds", xfer_word, hx);
        chk("R2", "tail holds", tail_word, ht);

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [15:0] rn;
            logic [2:0]  sz;
            rn = ($urandom_range(0, 9) < 7) ? (16'h1000 | 16'($urandom_range(0, 31)))
                                            : 16'($urandom());
            sz = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(2, 4))
                                            : 3'($urandom_range(0, 7));
            apply(mk(sz, 1'($urandom()), 1'($urandom_range(0, 9) < 8),
                     1'($urandom()), rn));
        end

        // back-to-back strobes
        @(negedge clk);
        cmd_bits = mk(3'd2, 1'b0, 1'b1, 1'b0, 16'h1001);
        start = 1'b1;
        @(negedge clk);
        cmd_bits = mk(3'd2, 1'b1, 1'b1, 1'b1, 16'h1002);
        @(negedge clk);
        start = 1'b0;
        chk("R2", "back-to-back valid", {31'd0, valid}, 32'd1);
        chk("R4", "back-to-back second word", xfer_word, 32'h4020_2023);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule